// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status-Tagged Receive Queue

This block recovers characters from an asynchronous serial line. It synchronizes the line, watches for a falling edge while idle, and confirms a start bit half a bit period later. It then takes each data bit, the optional parity bit and the stop bit one bit period apart. Each bit is the majority of three readings taken on consecutive oversample ticks around the sample point. Every finished character becomes one 12-bit queue entry that carries the data together with its own status flags.

Timing comes from two enables supplied from outside. `baud_tick` runs at twice the bit rate: the first tick after the start edge checks the start bit, and every second tick after that is a sample point. `os_tick` is a faster enable that paces the three readings of the vote. The frame configuration is captured at each start edge. A reader pops entries with `rd_en`, and the entry appears on `rd_data` one cycle later.

Entry layout: bits [7:0] hold the data, right-aligned and zero-extended. Bit 8 is the framing flag, bit 9 the parity flag, bit 10 the break flag and bit 11 the overrun flag.

Top module: `uart_rx_tagq`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `empty` is 1 and `full` is 0.
- R2: Data bits are taken least-significant first. The count is 5 + `cfg_len` (`cfg_len` 0..3 gives 5..8 bits). They land in entry bits [7:0] with the unused upper bits zero.
- R3: A low level that is high again when the start bit is checked, half a bit period after the edge, is a false start. It produces no entry.
- R4: Each bit is the majority of three consecutive `os_tick` readings. A disturbance no longer than one `os_tick` interval therefore does not change the received bit.
- R5: With `cfg_par_en` = 1, a parity bit follows the data. `cfg_par_odd` = 0 requires even parity over data plus parity bit, and 1 requires odd parity. A mismatch sets entry bit 9. With `cfg_par_en` = 0, bit 9 is 0.
- R6: A stop bit read as 0 sets entry bit 8. Reception still completes and the character is stored.
- R7: Entry bit 10 (break) is set when the data bits, the parity bit (if enabled) and the stop bit were all 0. A break entry also has bit 8 set.
- R8: A character that completes while the queue is full is discarded. Entry bit 11 is then set in the next entry that is stored, and it is 0 in the entries after that one.
- R9: The queue returns entries in arrival order. `rd_data` is updated in the cycle after a `rd_en` that found the queue non-empty. `empty` and `full` follow the number of entries held (2^`FIFO_AW`), and both are registered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high, asynchronous |
| baud_tick | input | 1 | Enable at twice the bit rate |
| os_tick | input | 1 | Oversample enable pacing the vote readings |
| cfg_len | input | 2 | Data bit count minus five |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_en | input | 1 | Pop one queue entry |
| rd_data | output | 12 | Popped entry: {overrun, break, parity, framing, data[7:0]} |
| empty | output | 1 | Queue holds no entry |
| full | output | 1 | Queue holds its maximum number of entries |

## Verification
Random frames mix all four lengths, both parity senses, parity on and off, and occasional corrupted parity or low stop bits. They start at varying phases against the baud grid, which separates bit-order and length errors from mistakes in the parity or framing flags. Directed cases cover the rest. An all-zero frame with a low stop bit separates break from a plain framing error. A short low pulse while idle must leave the queue empty. A one-interval glitch inside a data bit must not alter the data, which shows that the vote is a real majority and not a single reading. Filling the queue and adding one more character shows that the extra character is discarded, and that the overrun flag lands on the next stored entry only.

// File: rtl/uart_rx_tagq_pkg.sv
package uart_rx_tagq_pkg;

  localparam int RXQ_DATA_W = 8;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_RUN   = 2'd2
  } rx_state_e;

  // Queue entry, MSB first: overrun, break, parity, framing, data.
  typedef struct packed {
    logic                  ovr;
    logic                  brk;
    logic                  par_err;
    logic                  frm_err;
    logic [RXQ_DATA_W-1:0] data;
  } rx_entry_t;

  localparam int RXQ_ENTRY_W = $bits(rx_entry_t);

endpackage

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // Resets to the idle (marking) level.
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxq_vote3.sv
module rxq_vote3 (
  input  logic clk,
  input  logic rst,
  input  logic os_tick,
  input  logic req,
  input  logic din,
  output logic done,
  output logic bit_o
);
  logic [1:0] hist;
  logic [1:0] wait_cnt;

  // hist keeps the last two oversample readings. A request arms a count of two
  // oversample ticks; on the second one the two stored readings and the live
  // one form three consecutive samples centred on the first tick after req.
  always_ff @(posedge clk) begin
    if (rst) begin
      hist     <= 2'b11;
      wait_cnt <= 2'd0;
      done     <= 1'b0;
      bit_o    <= 1'b1;
    end else begin
      done <= 1'b0;
      if (os_tick) hist <= {hist[0], din};
      if (req) begin
        wait_cnt <= 2'd2;
      end else if (os_tick && wait_cnt != 2'd0) begin
        wait_cnt <= wait_cnt - 2'd1;
        if (wait_cnt == 2'd1) begin
          done  <= 1'b1;
          bit_o <= (hist[1] & hist[0]) | (hist[1] & din) | (hist[0] & din);
        end
      end
    end
  end
endmodule

// File: rtl/rxq_deframer.sv
module rxq_deframer
  import uart_rx_tagq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rxd_s,
  input  logic                  baud_tick,
  input  logic [1:0]            cfg_len,
  input  logic                  cfg_par_en,
  input  logic                  cfg_par_odd,
  input  logic                  vote_done,
  input  logic                  vote_bit,
  output logic                  samp_req,
  output logic                  chr_valid,
  output logic [RXQ_DATA_W-1:0] chr_data,
  output logic                  chr_fe,
  output logic                  chr_pe,
  output logic                  chr_brk
);
  localparam int POS_W = 4;
  localparam int IDX_W = $clog2(RXQ_DATA_W);

  rx_state_e             state;
  logic                  rxd_d;
  logic                  phase;
  logic [POS_W-1:0]      pos;
  logic [1:0]            len_q;
  logic                  par_en_q;
  logic                  par_odd_q;
  logic                  par_bit;
  logic [RXQ_DATA_W-1:0] data;

  logic [POS_W-1:0] n_data;
  logic [POS_W-1:0] par_pos;
  logic [POS_W-1:0] bidx;

  assign n_data  = POS_W'(5) + POS_W'(len_q);
  assign par_pos = n_data + POS_W'(1);
  assign bidx    = pos - POS_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      rxd_d     <= 1'b1;
      phase     <= 1'b0;
      pos       <= '0;
      len_q     <= '0;
      par_en_q  <= 1'b0;
      par_odd_q <= 1'b0;
      par_bit   <= 1'b0;
      data      <= '0;
      samp_req  <= 1'b0;
      chr_valid <= 1'b0;
      chr_data  <= '0;
      chr_fe    <= 1'b0;
      chr_pe    <= 1'b0;
      chr_brk   <= 1'b0;
    end else begin
      samp_req  <= 1'b0;
      chr_valid <= 1'b0;
      rxd_d     <= rxd_s;
      unique case (state)
        RX_IDLE: begin
          if (rxd_d && !rxd_s) begin
            state     <= RX_START;
            pos       <= '0;
            data      <= '0;
            par_bit   <= 1'b0;
            len_q     <= cfg_len;
            par_en_q  <= cfg_par_en;
            par_odd_q <= cfg_par_odd;
          end
        end
        RX_START: begin
          // first baud enable after the edge: half a bit in
          if (baud_tick) begin
            samp_req <= 1'b1;
            phase    <= 1'b0;
            state    <= RX_RUN;
          end
        end
        RX_RUN: begin
          if (baud_tick) begin
            phase <= ~phase;
            if (phase) samp_req <= 1'b1;
          end
          if (vote_done) begin
            pos <= pos + POS_W'(1);
            if (pos == '0) begin
              if (vote_bit) state <= RX_IDLE;  // false start
            end else if (pos <= n_data) begin
              data[bidx[IDX_W-1:0]] <= vote_bit;
            end else if (par_en_q && pos == par_pos) begin
              par_bit <= vote_bit;
            end else begin
              chr_valid <= 1'b1;
              chr_data  <= data;
              chr_fe    <= ~vote_bit;
              chr_pe    <= par_en_q & ((^data) ^ par_bit ^ par_odd_q);
              chr_brk   <= ~vote_bit & (data == '0) & ~(par_en_q & par_bit);
              state     <= RX_IDLE;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int WIDTH  = 12,
  parameter int ADDR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             empty,
  output logic             full
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0]  mem [DEPTH];
  logic [ADDR_W-1:0] wp;
  logic [ADDR_W-1:0] rp;
  logic [ADDR_W:0]   cnt;
  logic [ADDR_W:0]   cnt_nx;
  logic              do_wr;
  logic              do_rd;

  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & ~empty;

  always_comb begin
    cnt_nx = cnt;
    if (do_wr && !do_rd)      cnt_nx = cnt + (ADDR_W+1)'(1);
    else if (do_rd && !do_wr) cnt_nx = cnt - (ADDR_W+1)'(1);
  end

  // Storage and read register without reset so block RAM can be inferred.
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (do_rd) rd_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      cnt   <= '0;
      empty <= 1'b1;
      full  <= 1'b0;
    end else begin
      if (do_wr) wp <= wp + ADDR_W'(1);
      if (do_rd) rp <= rp + ADDR_W'(1);
      cnt   <= cnt_nx;
      empty <= (cnt_nx == '0);
      full  <= (cnt_nx == (ADDR_W+1)'(DEPTH));
    end
  end
endmodule

// File: rtl/uart_rx_tagq.sv
module uart_rx_tagq
  import uart_rx_tagq_pkg::*;
#(
  parameter int FIFO_AW     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   rxd,
  input  logic                   baud_tick,
  input  logic                   os_tick,
  input  logic [1:0]             cfg_len,
  input  logic                   cfg_par_en,
  input  logic                   cfg_par_odd,
  input  logic                   rd_en,
  output logic [RXQ_ENTRY_W-1:0] rd_data,
  output logic                   empty,
  output logic                   full
);
  logic                  rxd_s;
  logic                  samp_req;
  logic                  vote_done;
  logic                  vote_bit;
  logic                  chr_valid;
  logic [RXQ_DATA_W-1:0] chr_data;
  logic                  chr_fe;
  logic                  chr_pe;
  logic                  chr_brk;
  logic                  ovr_pend;
  logic                  push;
  rx_entry_t             entry;

  rxq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (rxd), .dout (rxd_s)
  );

  rxq_vote3 u_vote (
    .clk (clk), .rst (rst), .os_tick (os_tick), .req (samp_req),
    .din (rxd_s), .done (vote_done), .bit_o (vote_bit)
  );

  rxq_deframer u_deframe (
    .clk         (clk),
    .rst         (rst),
    .rxd_s       (rxd_s),
    .baud_tick   (baud_tick),
    .cfg_len     (cfg_len),
    .cfg_par_en  (cfg_par_en),
    .cfg_par_odd (cfg_par_odd),
    .vote_done   (vote_done),
    .vote_bit    (vote_bit),
    .samp_req    (samp_req),
    .chr_valid   (chr_valid),
    .chr_data    (chr_data),
    .chr_fe      (chr_fe),
    .chr_pe      (chr_pe),
    .chr_brk     (chr_brk)
  );

  // A full queue drops the character; the loss is flagged on the next store.
  assign push = chr_valid & ~full;

  always_ff @(posedge clk) begin
    if (rst)                   ovr_pend <= 1'b0;
    else if (chr_valid & full) ovr_pend <= 1'b1;
    else if (push)             ovr_pend <= 1'b0;
  end

  always_comb begin
    entry.ovr     = ovr_pend;
    entry.brk     = chr_brk;
    entry.par_err = chr_pe;
    entry.frm_err = chr_fe;
    entry.data    = chr_data;
  end

  rxq_fifo #(.WIDTH(RXQ_ENTRY_W), .ADDR_W(FIFO_AW)) u_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (push),
    .wr_data (entry),
    .rd_en   (rd_en),
    .rd_data (rd_data),
    .empty   (empty),
    .full    (full)
  );
endmodule

// File: rtl/uart_rx_tagq_checker.sv
module rxq_checker (
  input logic clk,
  input logic rst,
  input logic rd_en,
  input logic empty,
  input logic full,
  input logic push,
  input logic chr_valid,
  input logic chr_fe,
  input logic chr_brk
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (empty && !full)); // R1

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(empty && full)); // R9

  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty); // R9

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !rd_en) |=> full); // R8

  AST_BREAK_FRAMING: assert property (@(posedge clk) disable iff (rst)
    (chr_valid && chr_brk) |-> chr_fe); // R7
endmodule

bind uart_rx_tagq rxq_checker u_rxq_checker (
  .clk       (clk),
  .rst       (rst),
  .rd_en     (rd_en),
  .empty     (empty),
  .full      (full),
  .push      (push),
  .chr_valid (chr_valid),
  .chr_fe    (chr_fe),
  .chr_brk   (chr_brk)
);

// File: tb/test_uart_rx_tagq.sv
module test_uart_rx_tagq;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLKS   = 16;   // baud_tick every 8, os_tick every 2
  localparam int FIFO_AW    = 4;
  localparam int DEPTH      = 1 << FIFO_AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rxd = 1'b1;
  logic        baud_tick;
  logic        os_tick;
  logic [1:0]  cfg_len = 2'd3;
  logic        cfg_par_en = 1'b0;
  logic        cfg_par_odd = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_data;
  logic        empty;
  logic        full;

  int tcnt = 0;
  int n_checks = 0;
  int n_errors = 0;
  logic [11:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) tcnt <= tcnt + 1;
  assign os_tick   = (tcnt % 2 == 0);
  assign baud_tick = (tcnt % 8 == 0);

  uart_rx_tagq #(.FIFO_AW(FIFO_AW)) i_uart_rx_tagq (
    .clk (clk), .rst (rst), .rxd (rxd), .baud_tick (baud_tick), .os_tick (os_tick),
    .cfg_len (cfg_len), .cfg_par_en (cfg_par_en), .cfg_par_odd (cfg_par_odd),
    .rd_en (rd_en), .rd_data (rd_data), .empty (empty), .full (full)
  );

  function automatic logic [7:0] mask_data(logic [7:0] d, int len);
    return d & 8'(('h1 << (5 + len)) - 1);
  endfunction

  function automatic logic par_of(logic [7:0] d, int len, logic odd, logic flip);
    return (^mask_data(d, len)) ^ odd ^ flip;
  endfunction

  function automatic logic [11:0] exp_entry(logic [7:0] d, int len, logic pen, logic odd,
                                            logic flip, logic stop, logic ovr);
    logic [7:0] dm;
    logic       pb;
    logic       brk;
    dm  = mask_data(d, len);
    pb  = par_of(d, len, odd, flip);
    brk = !stop && (dm == 8'h00) && !(pen && pb);
    return {ovr, brk, pen & flip, ~stop, dm};
  endfunction

  task automatic check(input logic [11:0] act, input logic [11:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hold_bit(input logic b, input int glitch);
    rxd = b;
    if (glitch != 0) begin
      repeat (7) @(negedge clk);
      rxd = ~b;
      repeat (2) @(negedge clk);
      rxd = b;
      repeat (BIT_CLKS - 9) @(negedge clk);
    end else begin
      repeat (BIT_CLKS) @(negedge clk);
    end
  endtask

  task automatic send_frame(input logic [7:0] d, input int len, input logic pen, input logic odd,
                            input logic flip, input logic stop, input int glitch_bit);
    @(negedge clk);
    cfg_len = 2'(len); cfg_par_en = pen; cfg_par_odd = odd;
    hold_bit(1'b0, 0);
    for (int i = 0; i < 5 + len; i++) hold_bit(d[i], (i == glitch_bit) ? 1 : 0);
    if (pen) hold_bit(par_of(d, len, odd, flip), 0);
    hold_bit(stop, 0);
    hold_bit(1'b1, 0);
    hold_bit(1'b1, 0);
  endtask

  task automatic pop_check(input string req);
    logic [11:0] e;
    e = expq.pop_front();
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    check(rd_data, e, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int len;
    logic pen, odd, flip, stop;
    void'($urandom(32'h1234_abcd));
    repeat (4) @(negedge clk);
    check({10'd0, empty, full}, 12'b10, "R1 reset flags");
    rst = 1'b0;
    @(negedge clk);
    check({10'd0, empty, full}, 12'b10, "R1 after release");

    // Directed: 8 bits, even parity, clean
    send_frame(8'hA7, 3, 1'b1, 1'b0, 1'b0, 1'b1, -1);
    expq.push_back(exp_entry(8'hA7, 3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    check({11'd0, empty}, 12'd0, "R9 not empty after frame");
    pop_check("R2 8-bit frame");
    check({11'd0, empty}, 12'd1, "R9 empty after pop");

    // Directed: 5 bits, upper bits zero-extended (R2)
    send_frame(8'hFF, 0, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    expq.push_back(exp_entry(8'hFF, 0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    pop_check("R2 5-bit frame");

    // Directed: odd parity wrong (R5)
    send_frame(8'h3C, 2, 1'b1, 1'b1, 1'b1, 1'b1, -1);
    expq.push_back(exp_entry(8'h3C, 2, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    pop_check("R5 odd parity error");

    // Directed: framing error with nonzero data (R6)
    send_frame(8'h81, 3, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    expq.push_back(exp_entry(8'h81, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    pop_check("R6 framing error");

    // Directed: break, all zero (R7)
    send_frame(8'h00, 3, 1'b0, 1'b0, 1'b0, 1'b0, -1);
    expq.push_back(12'h500);
    pop_check("R7 break entry");

    // Directed: false start, short low pulse (R3)
    @(negedge clk) rxd = 1'b0;
    repeat (2) @(negedge clk);
    rxd = 1'b1;
    repeat (3 * BIT_CLKS) @(negedge clk);
    check({11'd0, empty}, 12'd1, "R3 false start ignored");

    // Directed: one-interval glitch in data bit 3 (R4)
    send_frame(8'h55, 3, 1'b1, 1'b0, 1'b0, 1'b1, 3);
    expq.push_back(exp_entry(8'h55, 3, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0));
    pop_check("R4 glitch rejected");

    // Random frames (R2, R5, R6, R7)
    for (int k = 0; k < 30; k++) begin
      d    = 8'($urandom);
      len  = int'($urandom % 4);
      pen  = 1'($urandom % 2);
      odd  = 1'($urandom % 2);
      flip = ($urandom % 5 == 0);
      stop = ($urandom % 8 != 0);
      send_frame(d, len, pen, odd, flip, stop, -1);
      expq.push_back(exp_entry(d, len, pen, odd, flip, stop, 1'b0));
      pop_check("R2 R5 R6 R7 random frame");
    end

    // Overrun (R8) and queue order (R9)
    for (int k = 0; k < DEPTH; k++) begin
      d = 8'($urandom);
      send_frame(d, 3, 1'b0, 1'b0, 1'b0, 1'b1, -1);
      expq.push_back(exp_entry(d, 3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    end
    check({11'd0, full}, 12'd1, "R9 full after filling");
    send_frame(8'hEE, 3, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    check({11'd0, full}, 12'd1, "R8 still full after drop");
    pop_check("R9 order head");
    pop_check("R9 order second");
    send_frame(8'h5A, 3, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    expq.push_back(exp_entry(8'h5A, 3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
    send_frame(8'hA5, 3, 1'b0, 1'b0, 1'b0, 1'b1, -1);
    expq.push_back(exp_entry(8'hA5, 3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    while (expq.size() > 0) pop_check("R8 R9 drain after overrun");
    check({10'd0, empty, full}, 12'b10, "R9 empty after drain");

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule